// File: doc/BRIEF.md
# Almost-Full Threshold Monitor

This block keeps a running count of the entries committed to a lookup table. It raises a warning when an insert brings that count exactly to a programmable threshold. The table write logic sends it one strobe per committed insert and one per committed delete. Entries still waiting in a queue are never reported to it, so they are never counted. A table reset strobe returns the count to zero.

The threshold is taken from the low 14 bits of a 16-bit register word when the load strobe is high. It may be reloaded at any time while the table is in use. A typical use is to program a threshold of half the table, wait for the warning, and then reprogram it to three quarters. The warning flag is sticky and is cleared only by its clear strobe. An interrupt pulse goes out together with the flag only when the interrupt enable is high.

Top module: `awm_almost_full_monitor`

## Requirements
- R1: After a synchronous active-low reset, entry_count is 0, af_threshold is 0, af_flag is 0 and af_irq is 0.
- R2: When thr_wr is high, af_threshold takes thr_word bits 13:0 on the next clock edge. Bits 15:14 of thr_word are ignored.
- R3: An ins_stb alone raises entry_count by one on the next edge. A del_stb alone lowers it by one. Both together leave it unchanged.
- R4: entry_count saturates at 16384, where a further insert is ignored. A delete at a count of 0 is also ignored.
- R5: tbl_reset clears entry_count to 0 on the next edge, overriding any insert or delete in the same cycle.
- R6: An accepted insert that makes the new count equal af_threshold sets af_flag on the next edge. The comparison uses the threshold held before any load in the same cycle.
- R7: A delete whose new count equals the threshold never sets af_flag. Neither does an insert whose new count differs from the threshold.
- R8: af_flag stays set until flag_clr is high for a cycle with no new hit. A hit in the same cycle as flag_clr keeps the flag set.
- R9: af_irq is a one-cycle pulse on the edge where a hit sets the flag, and only if irq_enable was high in the hit cycle.
- R10: A reloaded threshold governs the first insert after the load edge. This gives staged warnings at successive thresholds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_wr | input | 1 | Load the threshold from thr_word |
| thr_word | input | 16 | Register word; bits 13:0 form the threshold |
| ins_stb | input | 1 | One entry committed to the table |
| del_stb | input | 1 | One entry removed from the table |
| tbl_reset | input | 1 | Table reset: count to zero |
| flag_clr | input | 1 | Clear the sticky warning flag |
| irq_enable | input | 1 | Interrupt enable for the warning |
| entry_count | output | 15 | Committed entry count |
| af_threshold | output | 14 | Current threshold |
| af_flag | output | 1 | Sticky almost-full warning |
| af_irq | output | 1 | One-cycle warning interrupt pulse |

## Verification
Every result is due exactly one clock edge after the cycle that carries its stimulus. This holds for the count, the threshold, the flag and the interrupt pulse alike. No result takes two edges. The bench drives inputs on the falling edge. It updates a reference model with those inputs at the following rising edge and compares all four outputs shortly after that edge, so every check falls in the cycle its result is due. Random traffic uses small thresholds so that hits, deletes landing on the threshold and clears in the same cycle as a hit all occur often. Directed runs cover saturation, table reset priority and staged threshold reloads.

// File: rtl/awm_pkg.sv
// Shared sizing for the almost-full monitor.
// Assumes the table holds at most 2**THR_W entries.
package awm_pkg;
    localparam int unsigned AWM_WORD_W = 16;
    localparam int unsigned AWM_THR_W  = 14;
    localparam int unsigned AWM_CNT_W  = AWM_THR_W + 1;
    localparam int unsigned AWM_CNT_MAX = 1 << AWM_THR_W;

    // Kind of count change requested in one cycle
    typedef enum logic [1:0] {
        CHG_HOLD  = 2'd0,
        CHG_UP    = 2'd1,
        CHG_DOWN  = 2'd2,
        CHG_CLEAR = 2'd3
    } cnt_chg_e;
endpackage

// File: rtl/awm_entry_counter.sv
// Counts committed table entries.
// Saturates at CNT_MAX and floors at zero. Table reset has top priority.
// Also reports an accepted insert and the count it produces.
module awm_entry_counter #(
    parameter int unsigned CNT_W   = awm_pkg::AWM_CNT_W,
    parameter int unsigned CNT_MAX = awm_pkg::AWM_CNT_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_stb,
    input  logic             del_stb,
    input  logic             tbl_reset,
    output logic [CNT_W-1:0] count_q,
    output logic             ins_taken,
    output logic [CNT_W-1:0] count_after
);
    import awm_pkg::*;

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_MAX);

    cnt_chg_e chg;

    // Decode the requested change, dropping those the limits forbid
    always_comb begin
        chg = CHG_HOLD;
        if (tbl_reset)
            chg = CHG_CLEAR;
        else if (ins_stb && !del_stb && count_q < LIMIT)
            chg = CHG_UP;
        else if (del_stb && !ins_stb && count_q != '0)
            chg = CHG_DOWN;
    end

    // Next count value for the decoded change
    always_comb begin
        unique case (chg)
            CHG_UP:    count_after = count_q + 1'b1;
            CHG_DOWN:  count_after = count_q - 1'b1;
            CHG_CLEAR: count_after = '0;
            default:   count_after = count_q;
        endcase
    end

    assign ins_taken = (chg == CHG_UP);

    // Hold the committed count
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_after;
    end
endmodule

// File: rtl/awm_threshold_reg.sv
// Holds the almost-full threshold, loaded from the low THR_W bits of a word.
// Assumes WORD_W >= THR_W; upper word bits are dropped.
module awm_threshold_reg #(
    parameter int unsigned WORD_W = awm_pkg::AWM_WORD_W,
    parameter int unsigned THR_W  = awm_pkg::AWM_THR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic [THR_W-1:0]  thr_q
);
    // Capture the threshold field on a load
    always_ff @(posedge clk) begin
        if (!rst_n)    thr_q <= '0;
        else if (load) thr_q <= word[THR_W-1:0];
    end
endmodule

// File: rtl/awm_warn_logic.sv
// Sets the sticky warning flag and the gated interrupt pulse.
// Assumes the hit input is high only for an accepted insert.
module awm_warn_logic #(
    parameter int unsigned CNT_W = awm_pkg::AWM_CNT_W,
    parameter int unsigned THR_W = awm_pkg::AWM_THR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_taken,
    input  logic [CNT_W-1:0] count_after,
    input  logic [THR_W-1:0] thr_q,
    input  logic             flag_clr,
    input  logic             irq_enable,
    output logic             flag_q,
    output logic             irq_q
);
    logic hit;

    // Exact-equality match of the insert's new count against the threshold
    assign hit = ins_taken && (count_after == CNT_W'(thr_q));

    // Sticky flag: a set wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (hit)      flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    // One-cycle interrupt pulse for an enabled hit
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= hit && irq_enable;
    end
endmodule

// File: rtl/awm_almost_full_monitor.sv
// Top of the almost-full monitor. It joins the entry counter, the threshold
// register and the warning logic. Assumes the strobes come from committed table
// writes only; queued work is never reported here.
module awm_almost_full_monitor #(
    parameter int unsigned WORD_W  = awm_pkg::AWM_WORD_W,
    parameter int unsigned THR_W   = awm_pkg::AWM_THR_W,
    parameter int unsigned CNT_W   = THR_W + 1,
    parameter int unsigned CNT_MAX = 1 << THR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              thr_wr,
    input  logic [WORD_W-1:0] thr_word,
    input  logic              ins_stb,
    input  logic              del_stb,
    input  logic              tbl_reset,
    input  logic              flag_clr,
    input  logic              irq_enable,
    output logic [CNT_W-1:0]  entry_count,
    output logic [THR_W-1:0]  af_threshold,
    output logic              af_flag,
    output logic              af_irq
);
    logic             ins_taken;
    logic [CNT_W-1:0] count_after;

    awm_entry_counter #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ins_stb(ins_stb), .del_stb(del_stb),
        .tbl_reset(tbl_reset), .count_q(entry_count),
        .ins_taken(ins_taken), .count_after(count_after)
    );

    awm_threshold_reg #(.WORD_W(WORD_W), .THR_W(THR_W)) u_thr (
        .clk(clk), .rst_n(rst_n), .load(thr_wr), .word(thr_word),
        .thr_q(af_threshold)
    );

    awm_warn_logic #(.CNT_W(CNT_W), .THR_W(THR_W)) u_warn (
        .clk(clk), .rst_n(rst_n), .ins_taken(ins_taken),
        .count_after(count_after), .thr_q(af_threshold),
        .flag_clr(flag_clr), .irq_enable(irq_enable),
        .flag_q(af_flag), .irq_q(af_irq)
    );
endmodule

// File: rtl/awm_monitor_chk.sv
// Checker for the almost-full monitor, attached to the top by bind.
// Assumes inputs are low during reset.
module awm_monitor_chk #(
    parameter int unsigned CNT_W   = 15,
    parameter int unsigned THR_W   = 14,
    parameter int unsigned CNT_MAX = 16384
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ins_stb,
    input logic             del_stb,
    input logic             tbl_reset,
    input logic             flag_clr,
    input logic             irq_enable,
    input logic [CNT_W-1:0] entry_count,
    input logic [THR_W-1:0] af_threshold,
    input logic             af_flag,
    input logic             af_irq
);
    // R3
    count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_stb && !del_stb && !tbl_reset && entry_count < CNT_W'(CNT_MAX))
        |=> entry_count == $past(entry_count) + 1'b1);

    // R4
    count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_count <= CNT_W'(CNT_MAX));

    // R5
    tbl_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_reset |=> entry_count == '0);

    // R6
    hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_stb && !del_stb && !tbl_reset && entry_count < CNT_W'(CNT_MAX)
         && (entry_count + 1'b1) == CNT_W'(af_threshold)) |=> af_flag);

    // R7
    flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(af_flag) |-> $past(ins_stb) && !$past(del_stb) && !$past(tbl_reset));

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (af_flag && !flag_clr) |=> af_flag);

    // R9
    irq_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        af_irq |-> af_flag && $past(irq_enable));

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        af_irq |=> !af_irq || $past(ins_stb));
endmodule

bind awm_almost_full_monitor awm_monitor_chk #(
    .CNT_W(CNT_W), .THR_W(THR_W), .CNT_MAX(CNT_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ins_stb(ins_stb), .del_stb(del_stb),
    .tbl_reset(tbl_reset), .flag_clr(flag_clr), .irq_enable(irq_enable),
    .entry_count(entry_count), .af_threshold(af_threshold),
    .af_flag(af_flag), .af_irq(af_irq)
);

// File: tb/tb_awm_almost_full_monitor.sv
module tb_awm_almost_full_monitor;
    localparam int MAXC = 16384;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        thr_wr = 1'b0;
    logic [15:0] thr_word = '0;
    logic        ins_stb = 1'b0, del_stb = 1'b0, tbl_reset = 1'b0;
    logic        flag_clr = 1'b0, irq_enable = 1'b0;
    logic [14:0] entry_count;
    logic [13:0] af_threshold;
    logic        af_flag, af_irq;

    int checks = 0;
    int fails  = 0;
    int m_cnt = 0, m_thr = 0;
    bit m_flag = 0, m_irq = 0;

    always #10 clk = ~clk;

    awm_almost_full_monitor dut (
        .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .thr_word(thr_word),
        .ins_stb(ins_stb), .del_stb(del_stb), .tbl_reset(tbl_reset),
        .flag_clr(flag_clr), .irq_enable(irq_enable),
        .entry_count(entry_count), .af_threshold(af_threshold),
        .af_flag(af_flag), .af_irq(af_irq)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit hit_of(int cnt, int thr, bit i, bit d, bit c);
        return !c && i && !d && cnt < MAXC && (cnt + 1) == thr;
    endfunction

    // Apply one cycle of inputs, advance the model, compare all outputs
    task automatic tick(bit i, bit d, bit c, bit fc, bit ie, bit ld, logic [15:0] w);
        bit h;
        @(negedge clk);
        ins_stb = i; del_stb = d; tbl_reset = c; flag_clr = fc;
        irq_enable = ie; thr_wr = ld; thr_word = w;
        @(posedge clk);
        #1;
        h = hit_of(m_cnt, m_thr, i, d, c);
        m_flag = h ? 1'b1 : (fc ? 1'b0 : m_flag);
        m_irq  = h && ie;
        if (c) m_cnt = 0;
        else if (i && !d && m_cnt < MAXC) m_cnt++;
        else if (d && !i && m_cnt > 0) m_cnt--;
        if (ld) m_thr = int'(w[13:0]);
        check("R3 count", int'(entry_count), m_cnt);
        check("R2 threshold", int'(af_threshold), m_thr);
        check("R6 flag", int'(af_flag), int'(m_flag));
        check("R9 irq", int'(af_irq), int'(m_irq));
    endtask

    task automatic idle();
        tick(0, 0, 0, 0, 0, 0, 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 count", int'(entry_count), 0);
        check("R1 threshold", int'(af_threshold), 0);
        check("R1 flag", int'(af_flag), 0);
        check("R1 irq", int'(af_irq), 0);
        @(negedge clk); rst_n = 1'b1;

        // R2 upper word bits dropped
        tick(0, 0, 0, 0, 1, 1, 16'hC003);
        check("R2 low bits", int'(af_threshold), 3);
        // R6 R9 insert to threshold 3
        tick(1, 0, 0, 0, 1, 0, 0);
        tick(1, 0, 0, 0, 1, 0, 0);
        check("R6 no early flag", int'(af_flag), 0);
        tick(1, 0, 0, 0, 1, 0, 0);
        check("R6 flag on hit", int'(af_flag), 1);
        check("R9 irq on hit", int'(af_irq), 1);
        idle();
        check("R9 irq one cycle", int'(af_irq), 0);
        check("R8 sticky", int'(af_flag), 1);
        tick(0, 0, 0, 1, 1, 0, 0);
        check("R8 cleared", int'(af_flag), 0);
        // R7 insert past then delete back onto threshold
        tick(1, 0, 0, 0, 1, 0, 0);
        tick(0, 1, 0, 0, 1, 0, 0);
        check("R7 delete onto threshold", int'(af_flag), 0);
        check("R7 count", int'(entry_count), 3);
        // R3 simultaneous insert and delete
        tick(1, 1, 0, 0, 1, 0, 0);
        check("R3 both hold", int'(entry_count), 3);
        // R10 reload to 5, irq disabled at hit
        tick(0, 0, 0, 0, 0, 1, 16'h0005);
        tick(1, 0, 0, 0, 0, 0, 0);
        tick(1, 0, 0, 1, 0, 0, 0);
        check("R10 staged hit", int'(af_flag), 1);
        check("R9 irq gated off", int'(af_irq), 0);
        check("R8 set beats clear", int'(af_flag), 1);
        // R5 reset beats insert
        tick(1, 0, 1, 1, 0, 0, 0);
        check("R5 table reset", int'(entry_count), 0);
        tick(0, 1, 0, 0, 0, 0, 0);
        check("R4 floor at zero", int'(entry_count), 0);
        // R4 saturation, threshold out of reach
        tick(0, 0, 0, 0, 0, 1, 16'h0000);
        for (int k = 0; k < MAXC + 3; k++) tick(1, 0, 0, 0, 0, 0, 0);
        check("R4 saturate", int'(entry_count), MAXC);
        tick(1, 0, 1, 0, 0, 0, 0);

        // Random traffic with small thresholds
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = $urandom % 100;
            tick(r < 55, (r >= 45 && r < 80), ($urandom % 200) == 0,
                 ($urandom % 6) == 0, $urandom % 2, ($urandom % 25) == 0,
                 16'($urandom % 24) | (16'($urandom % 4) << 14));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule